// File: doc/BRIEF.md
# Folded-Table Lookup Multiplier

This block forms the unsigned product of two small operands by reading a precomputed table rather than building a partial-product adder array. Because swapping the operands never changes a product, the two inputs are first sorted into a larger value and a smaller value. That ordered pair selects one entry of a triangular table, so each unordered pair is stored once. With 4-bit operands the table has 136 entries, where a table indexed by the concatenated operands would have 256.

A build-time parameter selects a reduced variant. In that variant the smaller operand is tested first. When it is 0, 1 or 2, the product comes from simple select and shift logic. The table is read only when both operands are 3 or greater, which brings it down to 91 entries. In both variants a function fills the table during elaboration, so no memory image file is needed.

A caller places operands on `a` and `b` and pulses `in_valid`. One clock later the product appears on `product`, registered, and `out_valid` is high for that cycle. The registered product is held until the next strobe.

Top module: `mlut_mul`

## Requirements
- R1: A clock edge with `rst_n` low clears `out_valid` to 0 and `product` to 0 from the next cycle. This holds at power-up and in the middle of a run.
- R2: `out_valid` is high in exactly the cycle after an edge at which `in_valid` was sampled high, and it is low after every edge at which `in_valid` was low.
- R3: At an edge with `in_valid` high, `product` takes the full 8-bit unsigned value `a`×`b`. The corners 15×15 = 225 and 15×2 = 30 are included.
- R4: Operands given in swapped order, (`a`,`b`) and (`b`,`a`), return the same product.
- R5: After an edge with `in_valid` low, `product` keeps its previous value, whatever `a` and `b` carry.
- R6: With `REDUCED` = 1, a pair whose smaller operand is 0, 1 or 2 yields 0, the larger operand, or the larger operand shifted left by one bit. Every other pair comes from a 91-entry table. The result equals `a`×`b` for all 256 pairs.
- R7: With `REDUCED` = 0, every pair is read from a 136-entry table at slot hi×(hi+1)/2 + lo, where hi = max(`a`,`b`) and lo = min(`a`,`b`). The result equals `a`×`b` for all 256 pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: operands on `a`/`b` are taken this edge |
| a | input | 4 | First unsigned operand |
| b | input | 4 | Second unsigned operand |
| out_valid | output | 1 | High for one cycle when a new product is presented |
| product | output | 8 | Registered unsigned product |

## Verification
The bench builds two copies side by side, one with `REDUCED` = 0 and one with `REDUCED` = 1. Both are driven with the same stimulus and compared each cycle against one behavioural model. The full copy reaches every slot of the 136-entry triangle. The reduced copy reaches each of the three bypass paths as well as all 91 table slots. An exhaustive sweep over all 256 ordered pairs covers the diagonal, both orderings of every unordered pair, and the 15×15 corner. Idle gaps and a reset in the middle of the run exercise hold and clear.

// File: rtl/mlut_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing helpers for the folded lookup multiplier.
// Assumes operand widths of at least 2 bits when the reduced variant is used.
package mlut_pkg;

    // Number of slots in a triangle of side n (pairs with lo <= hi).
    function automatic int unsigned tri_count(input int unsigned n);
        return (n * (n + 1)) / 2;
    endfunction

    // Table depth for a given operand width and variant.
    function automatic int unsigned table_depth(input int unsigned opw, input bit reduced);
        int unsigned n;
        n = 1 << opw;
        return reduced ? tri_count(n - 3) : tri_count(n);
    endfunction

    // Smallest operand value that still goes through the table.
    function automatic int unsigned table_base(input bit reduced);
        return reduced ? 3 : 0;
    endfunction

endpackage

// File: rtl/mlut_order.sv
`timescale 1ns/1ps
// Module: mlut_order
// Sorts the two operands into a larger (hi) and smaller (lo) value so that
// swapped inputs land on the same table slot. Purely combinational.
module mlut_order #(
    parameter int OPW = 4
) (
    input  logic [OPW-1:0] op_x,
    input  logic [OPW-1:0] op_y,
    output logic [OPW-1:0] hi,
    output logic [OPW-1:0] lo
);

    // Pick the ordering with one magnitude compare.
    always_comb begin
        if (op_x >= op_y) begin
            hi = op_x;
            lo = op_y;
        end else begin
            hi = op_y;
            lo = op_x;
        end
    end

endmodule

// File: rtl/mlut_index.sv
`timescale 1ns/1ps
// Module: mlut_index
// Maps an ordered pair (hi >= lo) onto its slot in the triangular table:
// slot = h*(h+1)/2 + l with h, l offset by the table base. Also flags
// whether the pair is served by the table or by bypass logic.
// Assumes hi >= lo on its inputs.
module mlut_index #(
    parameter int OPW     = 4,
    parameter bit REDUCED = 1'b0,
    parameter int IW      = 8
) (
    input  logic [OPW-1:0] hi,
    input  logic [OPW-1:0] lo,
    output logic [IW-1:0]  slot,
    output logic           from_table
);
    import mlut_pkg::*;

    localparam int XW   = 2 * OPW;
    localparam int BASE = int'(table_base(REDUCED));

    logic [XW-1:0] h_off;
    logic [XW-1:0] l_off;
    logic [XW-1:0] row_start;
    logic [XW-1:0] flat;

    // Triangle row start plus column offset.
    always_comb begin
        h_off     = XW'(hi) - XW'(BASE);
        l_off     = XW'(lo) - XW'(BASE);
        row_start = (h_off * (h_off + 1'b1)) >> 1;
        flat      = row_start + l_off;
        slot      = IW'(flat);
    end

    // Table use depends on the variant.
    generate
        if (REDUCED) begin : g_reduced
            assign from_table = (lo >= OPW'(BASE));
        end else begin : g_full
            assign from_table = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/mlut_rom.sv
`timescale 1ns/1ps
// Module: mlut_rom
// Read-only triangular product table, filled at elaboration from the
// slot formula; no initialisation file. Out-of-range slots read zero.
module mlut_rom #(
    parameter int OPW     = 4,
    parameter bit REDUCED = 1'b0,
    parameter int DEPTH   = 136,
    parameter int IW      = 8
) (
    input  logic [IW-1:0]      slot,
    output logic [2*OPW-1:0]   data
);
    import mlut_pkg::*;

    localparam int PW   = 2 * OPW;
    localparam int N    = 1 << OPW;
    localparam int BASE = int'(table_base(REDUCED));

    logic [PW-1:0] rom [DEPTH];

    // One constant entry per unordered pair at or above the base.
    generate
        for (genvar h = BASE; h < N; h++) begin : g_row
            for (genvar l = BASE; l <= h; l++) begin : g_col
                localparam int SLOT = ((h - BASE) * (h - BASE + 1)) / 2 + (l - BASE);
                assign rom[SLOT] = PW'(h * l);
            end
        end
    endgenerate

    // Guarded read.
    always_comb begin
        if (int'(slot) < DEPTH) data = rom[slot];
        else                    data = '0;
    end

endmodule

// File: rtl/mlut_mul.sv
`timescale 1ns/1ps
// Module: mlut_mul (top)
// Unsigned multiplier by folded table lookup. Operands are sorted, mapped
// onto a triangular table, and the result is registered on in_valid.
// REDUCED=1 serves smaller-operand values 0, 1, 2 by select/shift logic.
// Assumes synchronous active-low reset; OPW >= 2.
module mlut_mul #(
    parameter int OPW     = 4,
    parameter bit REDUCED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    output logic             out_valid,
    output logic [2*OPW-1:0] product
);
    import mlut_pkg::*;

    localparam int PW    = 2 * OPW;
    localparam int DEPTH = int'(table_depth(OPW, REDUCED));
    localparam int IW    = $clog2(DEPTH);

    logic [OPW-1:0] hi;
    logic [OPW-1:0] lo;
    logic [IW-1:0]  slot;
    logic           from_table;
    logic [PW-1:0]  rom_data;
    logic [PW-1:0]  next_prod;

    mlut_order #(.OPW(OPW)) u_order (
        .op_x (a),
        .op_y (b),
        .hi   (hi),
        .lo   (lo)
    );

    mlut_index #(.OPW(OPW), .REDUCED(REDUCED), .IW(IW)) u_index (
        .hi         (hi),
        .lo         (lo),
        .slot       (slot),
        .from_table (from_table)
    );

    mlut_rom #(.OPW(OPW), .REDUCED(REDUCED), .DEPTH(DEPTH), .IW(IW)) u_rom (
        .slot (slot),
        .data (rom_data)
    );

    // Choose between table word and trivial-operand bypass.
    always_comb begin
        if (from_table) begin
            next_prod = rom_data;
        end else begin
            unique case (lo)
                OPW'(0): next_prod = '0;
                OPW'(1): next_prod = PW'(hi);
                default: next_prod = PW'(hi) << 1;
            endcase
        end
    end

    // Output register: capture on strobe, valid follows strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product <= next_prod;
        end
    end

endmodule

// File: rtl/mlut_mul_chk.sv
`timescale 1ns/1ps
// Module: mlut_mul_chk
// Port-level properties for mlut_mul, attached by bind below.
module mlut_mul_chk #(
    parameter int OPW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OPW-1:0]   a,
    input logic [OPW-1:0]   b,
    input logic             out_valid,
    input logic [2*OPW-1:0] product
);
    localparam int PW = 2 * OPW;

    // R1: reset clears valid and product
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));

    // R2: strobe produces valid next cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe, no valid
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: registered product equals arithmetic product of sampled operands
    a_r3_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> product == ($past(PW'(a)) * $past(PW'(b))));

    // R5: product held when idle
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> $stable(product));

endmodule

bind mlut_mul mlut_mul_chk #(.OPW(OPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/test_mlut_mul.sv
`timescale 1ns/1ps
// Bench: two copies (full and reduced) against one behavioural model.
module test_mlut_mul;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic       ov_f, ov_r;
    logic [7:0] pr_f, pr_r;

    int nchk = 0;
    int nerr = 0;
    int ev = 0;
    int ep = 0;
    int got_f [256];
    int got_r [256];

    always #4 clk = ~clk;

    mlut_mul #(.OPW(4), .REDUCED(1'b0)) i_mlut_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(ov_f), .product(pr_f));

    mlut_mul #(.OPW(4), .REDUCED(1'b1)) i_mlut_mul_rd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(ov_r), .product(pr_r));

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model after posedge, compare at next negedge.
    task automatic cyc(input bit r, input bit v, input int x, input int y,
                       input string vtag, input string ftag, input string rtag);
        rst_n    = r;
        in_valid = v;
        a        = x[3:0];
        b        = y[3:0];
        @(posedge clk);
        #1;
        if (!r) begin
            ev = 0;
            ep = 0;
        end else begin
            ev = v ? 1 : 0;
            if (v) ep = x * y;
        end
        @(negedge clk);
        check({vtag, " valid full"},    int'(ov_f), ev);
        check({vtag, " valid reduced"}, int'(ov_r), ev);
        check({ftag, " product full"},    int'(pr_f), ep);
        check({rtag, " product reduced"}, int'(pr_r), ep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        cyc(1'b0, 1'b0, 7, 9, "R1", "R1", "R1");
        cyc(1'b0, 1'b1, 5, 5, "R1", "R1", "R1");

        // R7 / R6 exhaustive sweep, back-to-back strobes
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                cyc(1'b1, 1'b1, x, y, "R2", "R7", "R6");
                got_f[x*16+y] = int'(pr_f);
                got_r[x*16+y] = int'(pr_r);
            end
        end

        // R4 swapped operands agree
        for (int x = 0; x < 16; x++) begin
            for (int y = x + 1; y < 16; y++) begin
                check("R4 swap full",    got_f[y*16+x], got_f[x*16+y]);
                check("R4 swap reduced", got_r[y*16+x], got_r[x*16+y]);
            end
        end

        // R3 corners
        cyc(1'b1, 1'b1, 15, 15, "R2", "R3", "R3");
        check("R3 corner 15x15", int'(pr_f), 225);
        cyc(1'b1, 1'b1, 15, 2, "R2", "R3", "R3");
        check("R3 corner 15x2", int'(pr_r), 30);

        // R5 hold while idle with changing operands
        cyc(1'b1, 1'b0, 3, 4, "R2", "R5", "R5");
        cyc(1'b1, 1'b0, 0, 0, "R2", "R5", "R5");
        cyc(1'b1, 1'b0, 9, 11, "R2", "R5", "R5");
        check("R5 held value", int'(pr_f), 30);

        // R6 bypass paths with gaps between strobes
        cyc(1'b1, 1'b1, 13, 2, "R2", "R3", "R6");
        cyc(1'b1, 1'b0, 1, 1, "R2", "R5", "R5");
        cyc(1'b1, 1'b1, 1, 14, "R2", "R3", "R6");
        cyc(1'b1, 1'b1, 0, 9, "R2", "R3", "R6");
        cyc(1'b1, 1'b1, 3, 3, "R2", "R7", "R6");
        cyc(1'b1, 1'b0, 2, 2, "R2", "R5", "R5");
        cyc(1'b1, 1'b1, 12, 7, "R2", "R7", "R6");

        // R1 reset mid-run clears product
        cyc(1'b0, 1'b1, 6, 6, "R1", "R1", "R1");
        check("R1 mid-run clear", int'(pr_r), 0);
        cyc(1'b1, 1'b1, 11, 13, "R2", "R3", "R6");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule